// File: doc/BRIEF.md
# Dual-Channel Change-Gated Gain Strobe Driver

This block sits between an automatic gain loop and two external step-gain amplifiers, one per receive channel. Each amplifier takes a 3-bit binary gain code, where each step is 6 dB. It latches that code when its own strobe line pulses. The block samples the loop's requested code for each channel once per update period, which is one eighth of the clock rate. It presents the sampled code on that channel's gain pins. It pulses that channel's strobe only when the code differs from the one last sent. Keeping the strobe idle when nothing changes keeps digital switching noise off the sensitive analog path.

Master reset and a synchronous initialise request both force the gain pins to a known reset code and hold both strobes high, so the amplifiers load that code. Each channel runs its own four-state machine:

- FORCE: reset or initialise is active.
- IDLE: waiting for an update tick.
- PEND: the gain pins have just changed.
- FIRE: the strobe is high.

Transitions:

- Any state goes to FORCE while reset or initialise is active.
- FORCE goes to IDLE once both are low.
- IDLE goes to PEND on an update tick whose sampled code differs from the stored one.
- IDLE stays in IDLE on a tick with an equal code, and when there is no tick.
- PEND goes to FIRE unconditionally.
- FIRE goes to IDLE unconditionally.

Top module: `gain_strobe_if`

## Requirements
- R1: While `rst` is high, both strobes are high and both gain outputs equal RESET_GAIN (default 3'b000).
- R2: While `sync_init` is high, both strobes are high from the next clock edge on and both gain outputs equal RESET_GAIN. The stored last-sent code is reloaded too, so a later update that requests RESET_GAIN produces no strobe.
- R3: Gain inputs are sampled only on update edges. These fall on the 8th rising edge after `rst` and `sync_init` are both low, and on every 8th edge after that. The gain output takes the new code on that edge and keeps its old value in the cycle before it.
- R4: Changes of a gain input between update edges have no effect on that channel's gain output or strobe.
- R5: When an update changes a channel's code, that channel's strobe stays low in the cycle after the update edge. It is high for exactly one cycle, the one after the next edge, and then returns low.
- R6: When an update samples a code equal to the last one sent, that channel's strobe stays low.
- R7: A code change on one channel never pulses the other channel's strobe.
- R8: Outside reset and initialise, the number of strobe-high cycles on each channel equals the number of code changes on that channel.
- R9: Between update edges and outside reset or initialise, the gain outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, active high, asynchronous |
| sync_init | input | 1 | Synchronous initialise request, active high |
| gain_a_in | input | 3 | Requested gain code, channel A |
| gain_b_in | input | 3 | Requested gain code, channel B |
| gain_a | output | 3 | Gain code to amplifier A |
| strobe_a | output | 1 | Latch strobe for amplifier A |
| gain_b | output | 3 | Gain code to amplifier B |
| strobe_b | output | 1 | Latch strobe for amplifier B |

## Verification
A corrupted last-sent register shows up at the next update edge, at most eight cycles later. It produces either a spurious strobe two cycles after that edge or a missing one, so the per-channel pulse count drifts from the count of code changes. A state machine stuck in PEND, FIRE or FORCE shows within one or two cycles as a strobe that is missing, doubled or held high. A wrong phase in the update counter moves every gain change away from its expected edge, and the sample taken one cycle before the update catches that at once.

// File: rtl/gsi_pkg.sv
package gsi_pkg;

    localparam int GAIN_W = 3;

    typedef logic [GAIN_W-1:0] gain_code_t;

    typedef enum logic [1:0] {
        ST_FORCE = 2'd0,
        ST_IDLE  = 2'd1,
        ST_PEND  = 2'd2,
        ST_FIRE  = 2'd3
    } chan_state_e;

endpackage

// File: rtl/gsi_update_tick.sv
module gsi_update_tick #(
    parameter int DECIM = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_i,
    output logic tick_o
);
    localparam int CNT_W = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DECIM - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (sync_i || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST) && !sync_i;

    // R3: consecutive ticks never occur when the period exceeds one
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o)
        else $error("tick repeated on consecutive cycles");

endmodule

// File: rtl/gsi_channel.sv
module gsi_channel
    import gsi_pkg::*;
#(
    parameter gain_code_t RESET_GAIN = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_i,
    input  logic       tick_i,
    input  gain_code_t code_i,
    output gain_code_t gain_o,
    output logic       strobe_o
);
    chan_state_e st_q, st_d;
    gain_code_t  sent_q;
    logic        differs;

    assign differs = (code_i != sent_q);

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= ST_FORCE;
        end else begin
            st_q <= st_d;
        end
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (sync_i) begin
            st_d = ST_FORCE;
        end else begin
            unique case (st_q)
                ST_FORCE: st_d = ST_IDLE;
                ST_IDLE:  st_d = (tick_i && differs) ? ST_PEND : ST_IDLE;
                ST_PEND:  st_d = ST_FIRE;
                ST_FIRE:  st_d = ST_IDLE;
                default:  st_d = ST_FORCE;
            endcase
        end
    end

    // output process: last-sent code register drives the gain pins
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sent_q <= RESET_GAIN;
        end else if (sync_i) begin
            sent_q <= RESET_GAIN;
        end else if (st_q == ST_IDLE && tick_i && differs) begin
            sent_q <= code_i;
        end
    end

    assign gain_o   = sent_q;
    assign strobe_o = (st_q == ST_FIRE) || (st_q == ST_FORCE);

    // R1: reset forces strobe and the reset code
    a_r1_reset_force: assert property (@(posedge clk)
        rst |-> (strobe_o && gain_o == RESET_GAIN))
        else $error("reset did not force strobe");

    // R2: initialise forces strobe and the reset code on the next edge
    a_r2_sync_force: assert property (@(posedge clk) disable iff (rst)
        sync_i |=> (strobe_o && gain_o == RESET_GAIN))
        else $error("initialise did not force strobe");

    // R5: a changed code produces a strobe two edges later
    a_r5_strobe_after_change: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && tick_i && differs && !sync_i) ##1 !sync_i |=> strobe_o)
        else $error("missing strobe after code change");

    // R5: the strobe lasts one cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_FIRE && !sync_i) |=> !strobe_o)
        else $error("strobe longer than one cycle");

    // R6: an unchanged code produces no strobe
    a_r6_no_strobe_same: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && tick_i && !differs && !sync_i) ##1 !sync_i |=> !strobe_o)
        else $error("strobe without code change");

    // R9: gain pins hold between update edges
    a_r9_gain_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !sync_i) |=> $stable(gain_o))
        else $error("gain changed off an update edge");

endmodule

// File: rtl/gain_strobe_if.sv
module gain_strobe_if
    import gsi_pkg::*;
#(
    parameter int         DECIM      = 8,
    parameter gain_code_t RESET_GAIN = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_init,
    input  logic [2:0] gain_a_in,
    input  logic [2:0] gain_b_in,
    output logic [2:0] gain_a,
    output logic       strobe_a,
    output logic [2:0] gain_b,
    output logic       strobe_b
);
    localparam int NUM_CH = 2;

    logic       tick;
    gain_code_t code_in  [NUM_CH];
    gain_code_t code_out [NUM_CH];
    logic       strb     [NUM_CH];

    gsi_update_tick #(.DECIM(DECIM)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .sync_i (sync_init),
        .tick_o (tick)
    );

    assign code_in[0] = gain_a_in;
    assign code_in[1] = gain_b_in;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        gsi_channel #(.RESET_GAIN(RESET_GAIN)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .sync_i   (sync_init),
            .tick_i   (tick),
            .code_i   (code_in[c]),
            .gain_o   (code_out[c]),
            .strobe_o (strb[c])
        );
    end

    assign gain_a   = code_out[0];
    assign strobe_a = strb[0];
    assign gain_b   = code_out[1];
    assign strobe_b = strb[1];

    // R7: a strobe outside reset/initialise needs its own channel's pins to have moved
    a_r7_independent_a: assert property (@(posedge clk) disable iff (rst || sync_init)
        (gain_a == $past(gain_a) && $past(gain_a) == $past(gain_a, 2) && !$past(sync_init)
         && !$past(sync_init, 2) && !$past(rst) && !$past(rst, 2)) |-> !strobe_a)
        else $error("channel A strobe without channel A change");

    a_r7_independent_b: assert property (@(posedge clk) disable iff (rst || sync_init)
        (gain_b == $past(gain_b) && $past(gain_b) == $past(gain_b, 2) && !$past(sync_init)
         && !$past(sync_init, 2) && !$past(rst) && !$past(rst, 2)) |-> !strobe_b)
        else $error("channel B strobe without channel B change");

endmodule

// File: tb/gain_strobe_if_test.sv
module gain_strobe_if_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_init = 1'b0;
    logic [2:0] gain_a_in = 3'd0;
    logic [2:0] gain_b_in = 3'd0;
    logic [2:0] gain_a, gain_b;
    logic       strobe_a, strobe_b;

    gain_strobe_if uut (
        .clk(clk), .rst(rst), .sync_init(sync_init),
        .gain_a_in(gain_a_in), .gain_b_in(gain_b_in),
        .gain_a(gain_a), .strobe_a(strobe_a),
        .gain_b(gain_b), .strobe_b(strobe_b)
    );

    always #2 clk = ~clk;

    typedef struct {
        int         due;
        logic [2:0] a, b, oa, ob;
        bit         sa, sb;
    } item_t;

    item_t q[$];
    int tests = 0, fails = 0;
    int cyc = 0;
    int force_end = 32'h7fffffff;
    int chg_a = 0, chg_b = 0, pulse_a = 0, pulse_b = 0;
    logic [2:0] model_a = 3'd0, model_b = 3'd0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // driver: one update period per call, starting at a negedge aligned to the period
    task automatic apply(input logic [2:0] a, input logic [2:0] b);
        item_t it;
        gain_a_in = a; gain_b_in = b;
        it.due = cyc + 8; it.a = a; it.b = b; it.oa = model_a; it.ob = model_b;
        it.sa = (a != model_a); it.sb = (b != model_b);
        if (it.sa) chg_a++;
        if (it.sb) chg_b++;
        model_a = a; model_b = b;
        q.push_back(it);
        repeat (8) @(negedge clk);
    endtask

    // R4: inputs wander between update edges and return before the edge
    task automatic apply_glitch(input logic [2:0] a, input logic [2:0] b,
                                input logic [2:0] ga, input logic [2:0] gb);
        item_t it;
        gain_a_in = a; gain_b_in = b;
        it.due = cyc + 8; it.a = a; it.b = b; it.oa = model_a; it.ob = model_b;
        it.sa = (a != model_a); it.sb = (b != model_b);
        if (it.sa) chg_a++;
        if (it.sb) chg_b++;
        model_a = a; model_b = b;
        q.push_back(it);
        repeat (2) @(negedge clk);
        gain_a_in = ga; gain_b_in = gb;
        repeat (3) @(negedge clk);
        gain_a_in = a; gain_b_in = b;
        repeat (3) @(negedge clk);
    endtask

    // R2: initialise pulse, realigns the update period
    task automatic do_sync();
        repeat (3) @(negedge clk);
        force_end = 32'h7fffffff;
        sync_init = 1'b1;
        @(negedge clk);
        chk(strobe_a && strobe_b, "R2 strobes forced", {strobe_a, strobe_b}, 3);
        chk(gain_a == 3'd0 && gain_b == 3'd0, "R2 reset code", {gain_a, gain_b}, 0);
        @(negedge clk);
        chk(strobe_a && strobe_b, "R2 strobes held", {strobe_a, strobe_b}, 3);
        sync_init = 1'b0;
        force_end = cyc;
        model_a = 3'd0; model_b = 3'd0;
    endtask

    // monitor / scoreboard
    item_t pend;
    bit pend_v = 0;
    always @(negedge clk) begin
        if (cyc > force_end) begin
            if (strobe_a) pulse_a++;
            if (strobe_b) pulse_b++;
        end
        if (pend_v && cyc == pend.due + 1) begin
            chk(strobe_a == pend.sa, pend.sa ? "R5 strobe A pulse" : "R6 strobe A idle",
                strobe_a, pend.sa);
            chk(strobe_b == pend.sb, pend.sb ? "R5 strobe B pulse" : "R7 strobe B idle",
                strobe_b, pend.sb);
        end
        if (pend_v && cyc == pend.due + 2) begin
            chk(!strobe_a && !strobe_b, "R5 strobes single cycle", {strobe_a, strobe_b}, 0);
            pend_v = 0;
        end
        if (q.size() > 0 && q[0].due - 1 == cyc) begin
            chk(gain_a == q[0].oa, "R3 gain A before edge", gain_a, q[0].oa);
            chk(gain_b == q[0].ob, "R3 gain B before edge", gain_b, q[0].ob);
        end
        if (q.size() > 0 && q[0].due == cyc) begin
            pend = q.pop_front();
            pend_v = 1;
            chk(gain_a == pend.a, "R3 R4 gain A updated", gain_a, pend.a);
            chk(gain_b == pend.b, "R3 R4 gain B updated", gain_b, pend.b);
            chk(!strobe_a && !strobe_b, "R5 strobe low on update cycle",
                {strobe_a, strobe_b}, 0);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(strobe_a && strobe_b, "R1 strobes during reset", {strobe_a, strobe_b}, 3);
        chk(gain_a == 3'd0 && gain_b == 3'd0, "R1 reset code", {gain_a, gain_b}, 0);
        rst = 1'b0;
        force_end = cyc;
        apply(3'd0, 3'd0);   // R6: equal to reset code, no strobes
        apply(3'd5, 3'd0);   // R7: only A changes
        apply(3'd5, 3'd2);   // R7: only B changes
        apply(3'd1, 3'd6);   // both change
        apply(3'd1, 3'd6);   // R6: repeat
        apply_glitch(3'd1, 3'd6, 3'd7, 3'd3);  // R4: wander then return
        apply_glitch(3'd4, 3'd6, 3'd0, 3'd0);  // R4 with a real A change
        do_sync();
        apply(3'd0, 3'd3);   // R2: A equals reset code, no strobe
        // R8: random sequence with frequent repeats
        for (int i = 0; i < 40; i++) begin
            logic [2:0] na, nb;
            na = ($urandom_range(0, 1) == 0) ? model_a : 3'($urandom_range(0, 7));
            nb = ($urandom_range(0, 2) == 0) ? 3'($urandom_range(0, 7)) : model_b;
            apply(na, nb);
        end
        repeat (4) @(negedge clk);
        chk(pulse_a == chg_a, "R8 pulse count A", pulse_a, chg_a);
        chk(pulse_b == chg_b, "R8 pulse count B", pulse_b, chg_b);
        finish_run();
    end

endmodule